// File: doc/BRIEF.md
# Graphic LCD Power-Up Initialization Sequencer

This block brings a 128x64 dot-matrix LCD controller out of power-on and into a displaying state over a four-wire serial link (chip select, command/data select, serial clock, serial data). After the system reset is released it waits a fixed power-settling time and pulses the panel's active-low hardware reset. After a further recovery wait it shifts out a fixed list of seventeen configuration command bytes. All of these steps need no help from the host.

Once the final display-enable command has fully left the shifter, the block raises `init_done` and opens a valid/ready byte stream. Each accepted byte goes out on the same link as display data, with the command/data line high. The panel is strapped for the 8-bit serial mode through constant mode outputs, and its unused read and write strobes are held low.

Top module: `lcd_init_seq`

## Requirements
- R1: After `rst_n` is released, `lcd_rst_n` and `lcd_cs_n` stay high and `lcd_sck` stays low until the POWER_WAIT_CYC-th rising clock edge. At that edge `lcd_rst_n` goes low.
- R2: `lcd_rst_n` stays low for exactly RST_LOW_CYC cycles. The first fall of `lcd_cs_n` comes RECOVER_CYC+1 cycles after `lcd_rst_n` returns high. No byte is sent while `lcd_rst_n` is low.
- R3: The configuration bytes leave in this order: E2, EB, 23, 29, 24, 89, C6, A0, 81, 5A, 2F, 40, B0, 10, 00, A6, AF (hex), each with `lcd_cd` = 0. The contrast setting is therefore the mode byte 81 followed by the value byte 5A as its own command.
- R4: Each byte is sent most significant bit first. `lcd_sda` changes only while `lcd_sck` is low and is sampled on the rising edge. Each high and each low half of `lcd_sck` lasts SCK_HALF_CYC cycles.
- R5: `lcd_cs_n` is low for exactly 16*SCK_HALF_CYC cycles per byte, covering all eight bits, and goes high between bytes. While `lcd_cs_n` is high, `lcd_sck` is low.
- R6: `init_done` rises only after the AF byte has completed and then stays high. Before that, `in_ready` is low, so a byte offered early is held off.
- R7: A byte accepted on the stream (`in_valid` and `in_ready` high at a rising edge) is shifted out with `lcd_cd` = 1, starting on the next cycle.
- R8: `lcd_ps` is 2'b00 (8-bit serial mode), and `lcd_rd` and `lcd_wr` are 0 at all times.
- R9: `in_ready` is low while a byte is being shifted. Stream bytes leave in the order they were accepted, including the values 00 and FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| in_data | input | 8 | Display-data byte offered by the host |
| in_valid | input | 1 | `in_data` holds a byte to send |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| init_done | output | 1 | Configuration list has been sent |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rst_n | output | 1 | Panel hardware reset, active low |
| lcd_cd | output | 1 | 0 = command byte, 1 = display data |
| lcd_sck | output | 1 | Serial clock |
| lcd_sda | output | 1 | Serial data |
| lcd_ps | output | 2 | Panel interface mode strap |
| lcd_rd | output | 1 | Panel read strobe, held low |
| lcd_wr | output | 1 | Panel write strobe, held low |

## Verification
The reset edge lands POWER_WAIT_CYC cycles after release, and the reset pulse lasts RST_LOW_CYC cycles. The first chip-select fall follows RECOVER_CYC+1 cycles after the reset line rises. Each byte then occupies 16*SCK_HALF_CYC cycles of chip select, and a stream byte starts one cycle after its handshake. The bench samples on the falling clock edge and counts those sample positions: it counts from one observed edge to the next, so it never waits a guessed delay. A serial decoder rebuilds each byte at the chip-select rise and checks it against a queue. The driver fills that queue at the moment each handshake completes, so timing and content are checked together.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int unsigned INIT_LEN = 17;

  typedef enum logic [2:0] {
    PH_POWER,
    PH_RESET,
    PH_RECOVER,
    PH_CONFIG,
    PH_STREAM
  } phase_t;

  // Bring-up command list, one entry per step of the sequence
  function automatic logic [7:0] init_byte(input logic [4:0] idx);
    case (idx)
      5'd0:    return 8'hE2;
      5'd1:    return 8'hEB;
      5'd2:    return 8'h23;
      5'd3:    return 8'h29;
      5'd4:    return 8'h24;
      5'd5:    return 8'h89;
      5'd6:    return 8'hC6;
      5'd7:    return 8'hA0;
      5'd8:    return 8'h81;
      5'd9:    return 8'h5A;
      5'd10:   return 8'h2F;
      5'd11:   return 8'h40;
      5'd12:   return 8'hB0;
      5'd13:   return 8'h10;
      5'd14:   return 8'h00;
      5'd15:   return 8'hA6;
      5'd16:   return 8'hAF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int unsigned longest(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles that chip select spends low for one byte
  function automatic int unsigned byte_cycles(input int unsigned half);
    return 16 * half;
  endfunction

endpackage

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
  import lcd_init_pkg::*;
(
  input  logic [4:0] idx,
  output logic [7:0] cmd
);
  always_comb cmd = init_byte(idx);
endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx #(
  parameter int unsigned HALF_DIV = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       cd_in,
  output logic       busy,
  output logic       done,
  output logic       cs_n,
  output logic       cd,
  output logic       sck,
  output logic       sda
);
  localparam int unsigned DW = $clog2(HALF_DIV + 1);

  logic [7:0]    sh;
  logic [2:0]    bit_q;
  logic [DW-1:0] div;
  logic          sck_q;
  logic          cd_q;
  logic          done_q;
  logic          half_tick;

  assign half_tick = busy && (div == DW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '0;
      bit_q  <= '0;
      div    <= '0;
      sck_q  <= 1'b0;
      cd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh    <= din;
          cd_q  <= cd_in;
          bit_q <= '0;
          div   <= '0;
          sck_q <= 1'b0;
        end
      end else if (half_tick) begin
        div <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh    <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

  assign done = done_q;
  assign cs_n = !busy;
  assign cd   = cd_q;
  assign sck  = sck_q;
  assign sda  = busy ? sh[7] : 1'b0;
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned POWER_WAIT_CYC = 500000,
  parameter int unsigned RST_LOW_CYC    = 500,
  parameter int unsigned RECOVER_CYC    = 250000,
  parameter int unsigned SCK_HALF_CYC   = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       init_done,
  output logic       lcd_cs_n,
  output logic       lcd_rst_n,
  output logic       lcd_cd,
  output logic       lcd_sck,
  output logic       lcd_sda,
  output logic [1:0] lcd_ps,
  output logic       lcd_rd,
  output logic       lcd_wr
);
  localparam int unsigned LONGEST = longest(POWER_WAIT_CYC, RST_LOW_CYC, RECOVER_CYC);
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [4:0]    idx;
  logic [7:0]    rom_byte;

  // Named internal events
  logic timer_expired;
  logic cmd_start;
  logic data_start;
  logic last_cmd;
  logic tx_busy;
  logic tx_done;
  logic tx_start;
  logic [7:0] tx_byte;

  lcd_cmd_rom u_rom (.idx(idx), .cmd(rom_byte));

  always_comb begin
    case (phase)
      PH_POWER:   limit = CW'(POWER_WAIT_CYC - 1);
      PH_RESET:   limit = CW'(RST_LOW_CYC - 1);
      PH_RECOVER: limit = CW'(RECOVER_CYC - 1);
      default:    limit = '0;
    endcase
  end

  assign timer_expired = (cnt == limit);
  assign last_cmd      = (idx == 5'(INIT_LEN - 1));
  assign cmd_start     = (phase == PH_CONFIG) && !tx_busy && !tx_done;
  assign in_ready      = (phase == PH_STREAM) && !tx_busy;
  assign data_start    = in_valid && in_ready;
  assign tx_start      = cmd_start || data_start;
  assign tx_byte       = (phase == PH_STREAM) ? in_data : rom_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_POWER;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (phase)
        PH_POWER, PH_RESET, PH_RECOVER: begin
          if (timer_expired) begin
            cnt <= '0;
            if (phase == PH_POWER)      phase <= PH_RESET;
            else if (phase == PH_RESET) phase <= PH_RECOVER;
            else                        phase <= PH_CONFIG;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_CONFIG: begin
          if (tx_done) begin
            if (last_cmd) phase <= PH_STREAM;
            else          idx   <= idx + 5'd1;
          end
        end
        default: ;
      endcase
    end
  end

  lcd_serial_tx #(.HALF_DIV(SCK_HALF_CYC)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .din   (tx_byte),
    .cd_in (phase == PH_STREAM),
    .busy  (tx_busy),
    .done  (tx_done),
    .cs_n  (lcd_cs_n),
    .cd    (lcd_cd),
    .sck   (lcd_sck),
    .sda   (lcd_sda)
  );

  assign lcd_rst_n = (phase != PH_RESET);
  assign init_done = (phase == PH_STREAM);
  assign lcd_ps    = 2'b00;
  assign lcd_rd    = 1'b0;
  assign lcd_wr    = 1'b0;
endmodule

// File: rtl/lcd_init_seq_checker.sv
module lcd_init_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic init_done,
  input logic lcd_cs_n,
  input logic lcd_rst_n,
  input logic lcd_cd,
  input logic lcd_sck,
  input logic lcd_sda
);
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_cs_n |-> !lcd_sck);

  assert_sda_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_sck && $past(lcd_sck)) |-> $stable(lcd_sda));

  assert_no_byte_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> lcd_cs_n);

  assert_cmd_is_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !init_done) |-> !lcd_cd);

  assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> init_done);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_data_is_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!lcd_cs_n && lcd_cd));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> lcd_cs_n);
endmodule

bind lcd_init_seq lcd_init_seq_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .init_done (init_done),
  .lcd_cs_n  (lcd_cs_n),
  .lcd_rst_n (lcd_rst_n),
  .lcd_cd    (lcd_cd),
  .lcd_sck   (lcd_sck),
  .lcd_sda   (lcd_sda)
);

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PWR  = 200;
  localparam int RSTL = 20;
  localparam int REC  = 30;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, init_done, lcd_cs_n, lcd_rst_n, lcd_cd, lcd_sck, lcd_sda;
  logic [1:0] lcd_ps;
  logic       lcd_rd, lcd_wr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_init_seq #(
    .POWER_WAIT_CYC(PWR), .RST_LOW_CYC(RSTL), .RECOVER_CYC(REC), .SCK_HALF_CYC(HALF)
  ) u_lcd_init_seq (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .init_done(init_done), .lcd_cs_n(lcd_cs_n),
    .lcd_rst_n(lcd_rst_n), .lcd_cd(lcd_cd), .lcd_sck(lcd_sck), .lcd_sda(lcd_sda),
    .lcd_ps(lcd_ps), .lcd_rd(lcd_rd), .lcd_wr(lcd_wr)
  );

  int n_checks = 0;
  int n_fails  = 0;
  logic [8:0] exp_q[$];
  int popped = 0;
  int early_ready = 0;
  int busy_ready  = 0;
  int strap_bad   = 0;
  int rst_send    = 0;
  bit done_seen   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Scoreboard monitor: rebuilds serial bytes at the falling clock edge
  logic       prev_sck, prev_cs, prev_sda;
  logic [7:0] rx;
  logic       rx_cd;
  int         bits, run_len, cs_len;
  logic [8:0] exp_item;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = 1'b0; prev_cs = 1'b1; prev_sda = 1'b0;
      bits = 0; run_len = 0; cs_len = 0; rx = '0; rx_cd = 1'b0;
    end else begin
      if (lcd_ps !== 2'b00 || lcd_rd !== 1'b0 || lcd_wr !== 1'b0) strap_bad++;
      if (in_ready && !init_done) early_ready++;
      if (in_ready && !lcd_cs_n) busy_ready++;
      if (!lcd_rst_n && !lcd_cs_n) rst_send++;
      if (init_done && !done_seen) begin
        done_seen = 1'b1;
        chk(popped == 17, "R6 init_done after all 17 bytes", popped, 17);
      end
      if (prev_cs && !lcd_cs_n) begin
        run_len = 1; cs_len = 1; bits = 0;
      end else begin
        if (!lcd_cs_n) cs_len++;
        if (lcd_sck != prev_sck) begin
          if (!prev_cs) chk(run_len == HALF, "R4 sck half period", run_len, HALF);
          run_len = 1;
        end else begin
          run_len++;
        end
        if (lcd_sck && prev_sck && lcd_sda != prev_sda)
          chk(1'b0, "R4 sda moved while sck high", lcd_sda, prev_sda);
        if (!prev_sck && lcd_sck && !lcd_cs_n) begin
          rx = {rx[6:0], lcd_sda};
          rx_cd = lcd_cd;
          bits++;
        end
        if (!prev_cs && lcd_cs_n) begin
          chk(bits == 8, "R5 eight bits per select", bits, 8);
          chk(cs_len == 16 * HALF, "R5 select low length", cs_len, 16 * HALF);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected byte", {rx_cd, rx}, 0);
          end else begin
            exp_item = exp_q.pop_front();
            chk({rx_cd, rx} == exp_item,
                exp_item[8] ? "R7 R9 data byte and cd" : "R3 command byte and cd",
                {rx_cd, rx}, exp_item);
          end
          popped++;
        end
      end
      prev_sck = lcd_sck; prev_cs = lcd_cs_n; prev_sda = lcd_sda;
    end
  end

  // Driver: offer one stream byte, record it when the handshake completes
  task automatic send(input logic [7:0] d);
    in_data  = d;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    exp_q.push_back({1'b1, d});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic timing_checks();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (lcd_rst_n);
    chk(n == PWR, "R1 power wait length", n, PWR);
    n = 0;
    do begin @(negedge clk); n++; end while (!lcd_rst_n);
    chk(n == RSTL, "R2 reset pulse length", n, RSTL);
    n = 0;
    do begin @(negedge clk); n++; end while (lcd_cs_n);
    chk(n == REC + 1, "R2 recovery before first byte", n, REC + 1);
  endtask

  localparam logic [7:0] INIT_LIST [17] = '{
    8'hE2, 8'hEB, 8'h23, 8'h29, 8'h24, 8'h89, 8'hC6, 8'hA0, 8'h81,
    8'h5A, 8'h2F, 8'h40, 8'hB0, 8'h10, 8'h00, 8'hA6, 8'hAF};

  initial begin
    for (int i = 0; i < 17; i++) exp_q.push_back({1'b0, INIT_LIST[i]});
    repeat (5) @(negedge clk);
    chk(lcd_cs_n === 1'b1 && lcd_rst_n === 1'b1 && lcd_sck === 1'b0,
        "R1 reset state of link", {lcd_cs_n, lcd_rst_n, lcd_sck}, 3'b110);
    chk(init_done === 1'b0 && in_ready === 1'b0, "R6 reset state of flags",
        {init_done, in_ready}, 0);
    chk(lcd_ps === 2'b00 && lcd_rd === 1'b0 && lcd_wr === 1'b0, "R8 strap in reset",
        {lcd_ps, lcd_rd, lcd_wr}, 0);
    rst_n = 1'b1;
    fork
      timing_checks();
      send(8'hA5);
    join
    send(8'h00);
    send(8'hFF);
    send(8'h3C);
    while (exp_q.size() != 0 || !lcd_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(popped == 21, "R9 all stream bytes sent", popped, 21);
    chk(early_ready == 0, "R6 ready held off before done", early_ready, 0);
    chk(busy_ready == 0, "R9 ready low while shifting", busy_ready, 0);
    chk(strap_bad == 0, "R8 mode strap and strobes", strap_bad, 0);
    chk(rst_send == 0, "R2 no byte during reset", rst_send, 0);
    chk(init_done === 1'b1, "R6 init_done stays high", init_done, 1);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule